// File: doc/BRIEF.md
# LCD Sync and Pixel Timing Generator

This block produces the line sync, frame sync and data-valid window for a 320 x 240 TFT panel. It can drive the panel over a 16-bit pixel bus. It can also drive it over an 8-bit bus, where each pixel is sent as two or three bytes. A two-bit mode input picks the bus format. Every horizontal figure scales with the number of clocks per pixel that the mode implies. For the byte-bus modes, a small extra delay is added before the first pixel of a line. This delay lines the output up with the pipeline of an external bus-width converter.

An upstream unit presents the current pixel word on `pixel_in`. The block pulses `pixel_next` on the last tick spent on that word, and the upstream unit then moves to the next pixel. A one-cycle `frame_start` pulse marks tick zero of every frame, so a fetch unit can rewind its address.

The controller has two states:
- `ST_IDLE`: outputs are inactive, the counters are held at zero and the mode is sampled.
- `ST_RUN`: the counters advance one tick per clock.

The transitions are `ST_IDLE -> ST_RUN` when `enable` is high and `ST_RUN -> ST_IDLE` when `enable` is low.

Top module: `lcdt_sync_gen`

## Requirements
- R1: While reset is asserted, and in the disabled state, `hsync_n` and `vsync_n` are 1, while `data_valid`, `data_out`, `pixel_next` and `frame_start` are 0.
- R2: Mode encoding is as follows. 2'b00 is 16-bit RGB565 (1 clock per pixel, correction 0). 2'b01 is 8-bit RGB565 (2 clocks per pixel, correction 3). 2'b10 is 8-bit RGB888 (3 clocks per pixel, correction 5). 2'b11 behaves exactly as 2'b00. A line lasts 336 x cpp ticks, where cpp is clocks per pixel.
- R3: A frame has 244 lines and lasts 336 x cpp x 244 ticks. `vsync_n` is low during ticks 0 to 2 x cpp - 1 of line 0 only.
- R4: `hsync_n` is low during ticks 0 to 2 x cpp - 1 of every line.
- R5: The valid window begins at tick 7 x cpp + correction of a line and lasts 320 x cpp ticks. `data_valid` is high only inside this window and only on lines 2 to 241. Lines 0, 1, 242 and 243 carry no data.
- R6: In mode 00/11, `data_out` equals `pixel_in[15:0]` on valid ticks, and `pixel_next` is high on every valid tick. In the 8-bit modes, `data_out[15:8]` is 0 and `data_out[7:0]` carries the pixel most significant byte first. Mode 01 sends bits 15:8, then 7:0. Mode 10 sends bits 23:16, then 15:8, then 7:0. `pixel_next` is high on the last byte of each pixel. `data_out` is 0 when not valid.
- R7: `frame_start` is a registered output that is high for exactly the one tick where line and tick counters are both zero.
- R8: If `enable` is low at a clock edge, all outputs are inactive from the following cycle. The first cycle after enabling is tick 0 of line 0, so both counters restart from zero.
- R9: The mode is captured only in the disabled state. A mode change while enabled has no effect on timing or data until the block has been disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces idle |
| mode | input | 2 | Bus format select (see R2) |
| pixel_in | input | 24 | Current pixel word from upstream |
| hsync_n | output | 1 | Active-low line sync |
| vsync_n | output | 1 | Active-low frame sync |
| data_valid | output | 1 | Tick carries pixel data |
| data_out | output | 16 | Pixel word or byte to the panel bus |
| pixel_next | output | 1 | Last tick of the current pixel word |
| frame_start | output | 1 | Registered tick-zero-of-frame marker |

## Verification
A wrong tick count shows up within one line period as a sync or valid edge on the wrong tick. A wrong line count shows within one frame, when the frame-start pulse or the vertical sync lands on the wrong line. A stale byte phase or mode register corrupts `data_out` on the first valid tick after the fault. The bench therefore compares every output against a tick-indexed reference on every clock, including full frames in the fastest mode and several lines in each byte mode.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lcdt_state_t;

    // clocks per pixel for a bus mode; 2'b11 aliases 2'b00
    function automatic logic [1:0] cpp_of(input logic [1:0] m);
        case (m)
            2'b01:   return 2'd2;
            2'b10:   return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // first-pixel delay added for the external converter pipeline
    function automatic logic [2:0] corr_of(input logic [1:0] m,
                                           input logic [2:0] c16,
                                           input logic [2:0] c24);
        case (m)
            2'b01:   return c16;
            2'b10:   return c24;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/lcdt_wrap_counter.sv
module lcdt_wrap_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    assign at_last = (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/lcdt_byte_ser.sv
module lcdt_byte_ser (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        win,
    input  logic [1:0]  cpp,
    input  logic [23:0] pixel,
    output logic [7:0]  byte_out,
    output logic        last_byte
);
    logic [1:0] phase;
    logic [1:0] idx;

    assign last_byte = (phase == cpp - 2'd1);
    assign idx       = cpp - 2'd1 - phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= 2'd0;
        else if (!win || last_byte)
            phase <= 2'd0;
        else
            phase <= phase + 2'd1;
    end

    always_comb begin
        case (idx)
            2'd2:    byte_out = pixel[23:16];
            2'd1:    byte_out = pixel[15:8];
            default: byte_out = pixel[7:0];
        endcase
    end
endmodule

// File: rtl/lcdt_sync_gen.sv
module lcdt_sync_gen
    import lcdt_pkg::*;
#(
    parameter int H_ACT   = 320,
    parameter int H_TOT   = 336,
    parameter int H_SYNC  = 2,
    parameter int H_LEAD  = 7,
    parameter int V_ACT   = 240,
    parameter int V_BLANK = 4,
    parameter int CORR16  = 3,
    parameter int CORR24  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [1:0]  mode,
    input  logic [23:0] pixel_in,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic        data_valid,
    output logic [15:0] data_out,
    output logic        pixel_next,
    output logic        frame_start
);
    localparam int HW    = $clog2(H_TOT * 3 + 1);
    localparam int V_TOT = V_ACT + V_BLANK;
    localparam int V_TOP = V_BLANK / 2;
    localparam int VW    = $clog2(V_TOT + 1);

    lcdt_state_t state, state_nx;
    logic [1:0]    mode_q;
    logic          fs_q;
    logic [1:0]    cpp;
    logic [2:0]    corr;
    logic [HW-1:0] h_last, h_sync_end, h_start, h_stop, h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_wrap, v_wrap, h_win, line_act, run, last_byte;
    logic [7:0]    ser_byte;

    assign run  = (state == ST_RUN);
    assign cpp  = cpp_of(mode_q);
    assign corr = corr_of(mode_q, 3'(CORR16), 3'(CORR24));

    assign h_last     = HW'(H_TOT) * HW'(cpp) - HW'(1);
    assign h_sync_end = HW'(H_SYNC) * HW'(cpp);
    assign h_start    = HW'(H_LEAD) * HW'(cpp) + HW'(corr);
    assign h_stop     = h_start + HW'(H_ACT) * HW'(cpp);

    // state transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (enable)  state_nx = ST_RUN;
            ST_RUN:  if (!enable) state_nx = ST_IDLE;
        endcase
    end

    // state register, mode capture, frame-start marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= 2'b00;
            fs_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE)
                mode_q <= mode;
            fs_q <= (state_nx == ST_RUN) &&
                    ((state == ST_IDLE) || (h_wrap && v_wrap));
        end
    end

    lcdt_wrap_counter #(.W(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(1'b1),
        .last(h_last), .cnt(h_cnt), .at_last(h_wrap)
    );

    lcdt_wrap_counter #(.W(VW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(h_wrap),
        .last(VW'(V_TOT - 1)), .cnt(v_cnt), .at_last(v_wrap)
    );

    assign h_win    = run && (h_cnt >= h_start) && (h_cnt < h_stop);
    assign line_act = (v_cnt >= VW'(V_TOP)) && (v_cnt < VW'(V_TOP + V_ACT));

    lcdt_byte_ser u_ser (
        .clk(clk), .rst_n(rst_n), .win(h_win), .cpp(cpp),
        .pixel(pixel_in), .byte_out(ser_byte), .last_byte(last_byte)
    );

    // outputs
    always_comb begin
        hsync_n     = 1'b1;
        vsync_n     = 1'b1;
        data_valid  = 1'b0;
        data_out    = 16'h0000;
        pixel_next  = 1'b0;
        frame_start = fs_q;
        if (run) begin
            hsync_n    = !(h_cnt < h_sync_end);
            vsync_n    = !((v_cnt == '0) && (h_cnt < h_sync_end));
            data_valid = h_win && line_act;
            if (data_valid) begin
                data_out   = (cpp == 2'd1) ? pixel_in[15:0] : {8'h00, ser_byte};
                pixel_next = last_byte;
            end
        end
    end
endmodule

// File: rtl/lcdt_sync_checker.sv
module lcdt_sync_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic hsync_n,
    input logic vsync_n,
    input logic data_valid,
    input logic pixel_next,
    input logic frame_start
);
    assert_hsync_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hsync_n) && enable) |=> !hsync_n);

    assert_valid_outside_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (hsync_n && vsync_n));

    assert_next_within_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_next |-> data_valid);

    assert_start_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!vsync_n && !hsync_n));

    assert_vsync_edge_is_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> frame_start);

    assert_disable_quiets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hsync_n && vsync_n && !data_valid && !frame_start));
endmodule

bind lcdt_sync_gen lcdt_sync_checker u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .data_valid(data_valid),
    .pixel_next(pixel_next), .frame_start(frame_start)
);

// File: tb/tb_lcdt_sync_gen.sv
`timescale 1ns/1ps
module tb_lcdt_sync_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [23:0] pixel_in = 24'h0;
    logic        hsync_n, vsync_n, data_valid, pixel_next, frame_start;
    logic [15:0] data_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int fs_count = 0;
    string ctx = "R2";

    // behavioural reference state
    bit m_run = 0;
    int m_t = 0;
    int m_mode = 0;

    always #5 clk = ~clk;

    lcdt_sync_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .pixel_in(pixel_in), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .data_valid(data_valid), .data_out(data_out),
        .pixel_next(pixel_next), .frame_start(frame_start)
    );

    function automatic int f_cpp(int m);
        return (m == 1) ? 2 : (m == 2) ? 3 : 1;
    endfunction
    function automatic int f_corr(int m);
        return (m == 1) ? 3 : (m == 2) ? 5 : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0d mode=%0d: actual %0h expected %0h", tag, m_t, m_mode, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // reference update at the active edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_t = 0; m_mode = 0;
        end else if (!m_run) begin
            m_mode = int'(mode);
            if (enable) begin m_run = 1; m_t = 0; end
        end else if (!enable) begin
            m_run = 0;
        end else begin
            m_t = m_t + 1;
            if (m_t == 336 * f_cpp(m_mode) * 244) m_t = 0;
        end
    end

    // comparison away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            int cpp, hp, h, v, st, e_hs, e_vs, e_val, e_dat, e_nx, e_fs, ph;
            cpp = f_cpp(m_mode); hp = 336 * cpp;
            h = m_t % hp; v = m_t / hp;
            st = 7 * cpp + f_corr(m_mode);
            e_hs = 1; e_vs = 1; e_val = 0; e_dat = 0; e_nx = 0; e_fs = 0;
            if (m_run) begin
                e_hs = (h < 2 * cpp) ? 0 : 1;
                e_vs = (v == 0 && h < 2 * cpp) ? 0 : 1;
                e_val = (h >= st && h < st + 320 * cpp && v >= 2 && v < 242) ? 1 : 0;
                e_fs = (m_t == 0) ? 1 : 0;
                if (e_val == 1) begin
                    ph = (h - st) % cpp;
                    if (cpp == 1) e_dat = int'(pixel_in[15:0]);
                    else e_dat = int'((pixel_in >> ((cpp - 1 - ph) * 8)) & 24'hFF);
                    e_nx = (ph == cpp - 1) ? 1 : 0;
                end
                check({ctx, "/R4 hsync"}, int'(hsync_n), e_hs);
                check({ctx, "/R3 vsync"}, int'(vsync_n), e_vs);
                check({ctx, "/R5 valid"}, int'(data_valid), e_val);
                check({ctx, "/R6 data"}, int'(data_out), e_dat);
                check({ctx, "/R6 next"}, int'(pixel_next), e_nx);
                check({ctx, "/R7 frame_start"}, int'(frame_start), e_fs);
            end else begin
                check("R8 idle outputs", {hsync_n, vsync_n, data_valid, pixel_next, frame_start},
                      5'b11000);
                check("R8 idle data", int'(data_out), 0);
            end
            if (frame_start) fs_count++;
        end
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    // pixel stimulus changes on the falling edge
    always @(negedge clk) pixel_in <= pixel_in * 24'd5 + 24'h3C5A7;

    task automatic run_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run_cycles(3);
        // R1: reset state
        check("R1 reset syncs", {hsync_n, vsync_n}, 2'b11);
        check("R1 reset valid/next/start", {data_valid, pixel_next, frame_start}, 3'b000);
        check("R1 reset data", int'(data_out), 0);
        rst_n = 1'b1;
        run_cycles(5);

        // R2/R3: full frames in 16-bit mode
        ctx = "R2 m00"; mode = 2'b00; enable = 1'b1;
        run_cycles(336 * 244 + 700);
        check("R3 R7 frame_start count over frame wrap", fs_count, 2);

        enable = 1'b0; run_cycles(4);

        // R9: mode change while running has no effect
        ctx = "R9 m01"; mode = 2'b01; enable = 1'b1;
        run_cycles(1500);
        mode = 2'b10;
        run_cycles(1500);
        enable = 1'b0; run_cycles(3);

        // RGB888 on 8 bits
        ctx = "R2 m10"; enable = 1'b1;
        run_cycles(3200);

        // R8: short disable then restart from zero
        enable = 1'b0; run_cycles(1);
        ctx = "R8 restart"; enable = 1'b1;
        run_cycles(100);

        // reserved code behaves as 16-bit
        enable = 1'b0; run_cycles(2);
        ctx = "R2 m11"; mode = 2'b11; enable = 1'b1;
        run_cycles(1500);
        enable = 1'b0; run_cycles(3);

        finish_run();
    end
endmodule